// File: doc/BRIEF.md
# Receiver Error-Flag and Clock-Fallback Controller

This block sits behind the biphase decoder of a digital audio interface receiver and decides when the received stream may be trusted. It combines the PLL lock level, data-error pulses, sample-rate change events and the non-PCM detector into one error flag and one audio mute. After lock is gained, the flag stays raised until a programmable number of block-start preambles has been seen. Any new lock loss or error event restarts that count.

A separate timer watches for loss of lock and asks the clock tree to fall back to the crystal clock. The request comes either at once or after a programmable delay, measured in system-clock cycles derived from a clock-frequency parameter. A per-subframe parity flag is also produced, and its reporting rule is selectable. All options come from one 8-bit configuration byte. The byte is loaded through a write strobe and resets to zero.

Top module: `audio_errflag_ctrl`

## Requirements
- R1: After reset the configuration byte is 0x00, `err_flag` and `audio_mute` are 1, and `parity_flag` is 0 while no parity error is presented.
- R2: Configuration bits [7:6] select the release count: 00 means 3 preambles, 01 means 24, 10 means 12 and 11 means 6. With the lock held and no error event, `err_flag` stays 1 until the clock edge that samples the last of those `blk_start_p` pulses. It reads 0 from the following cycle.
- R3: A cycle with `pll_locked` low, with a `data_err_p` pulse, or with a counted fs change clears the preamble count. `err_flag` is then 1 from the next cycle until the full count has been seen again.
- R4: With configuration bit 0 at 1, `err_flag` is also 1 in every cycle in which `nonpcm_det` is 1. With bit 0 at 0, `nonpcm_det` has no effect on `err_flag`.
- R5: `audio_mute` is 1 while the preamble count has not completed, and also while `nonpcm_det` is 1 with configuration bit 0 at 1. In all other cases it is 0.
- R6: With configuration bit 4 at 1, `err_flag` is 1 unconditionally. This bit has no effect on `audio_mute`.
- R7: With configuration bit 5 at 0, an fs-change pulse restarts the error period as in R3. With bit 5 at 1, fs-change pulses are ignored.
- R8: While `osc_running` is 0, `fs_chg_calc_p` is ignored. `fs_chg_cs_p` still counts.
- R9: Configuration bits [3:2] select the fallback delay after unlock: 00 is 200 us, 01 is 100 us and 10 is 50 us. The delay is counted as CLK_KHZ*us/1000 consecutive unlocked clock edges, after which `clk_switch_req` is 1 until lock returns. `clk_switch_req` is 0 whenever `pll_locked` is 1.
- R10: With configuration bits [3:2] at 11, `clk_switch_req` is 1 in the same cycle that `pll_locked` is 0.
- R11: With configuration bit 1 at 0, `parity_flag` equals `parity_err_p` AND `nonpcm_det`. With bit 1 at 1, it equals `parity_err_p`, so it is raised only in the subframe that had the error.
- R12: The configuration byte changes only at a clock edge where `cfg_we` is 1. With `cfg_we` at 0, `cfg_wdata` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to load |
| pll_locked | input | 1 | PLL lock level |
| data_err_p | input | 1 | Data-error pulse from the decoder |
| parity_err_p | input | 1 | Parity-error pulse for the current subframe |
| nonpcm_det | input | 1 | Non-PCM stream detected level |
| blk_start_p | input | 1 | Block-start preamble strobe |
| fs_chg_calc_p | input | 1 | fs change from the rate calculator |
| fs_chg_cs_p | input | 1 | fs change from channel status |
| osc_running | input | 1 | Crystal oscillator running level |
| err_flag | output | 1 | Receiver error flag |
| audio_mute | output | 1 | Audio output mute |
| clk_switch_req | output | 1 | Request to switch to the fallback clock |
| parity_flag | output | 1 | Reported parity error |

## Verification
Two functions can meet in the same cycle. The forced-error bit and the non-PCM source can both drive the flag, while the mute must follow only the non-PCM path. The bench sets force together with non-PCM detection, then force alone, and checks flag and mute separately in each state. A lock loss that restarts the preamble count also starts the fallback timer in that same cycle. The bench therefore drops lock while the count is in progress. It then checks that the flag is raised one edge later and that the clock-switch request appears exactly at the programmed edge count.

// File: rtl/aef_pkg.sv
package aef_pkg;

    localparam int CFG_W     = 8;
    localparam int PRE_CNT_W = 5;
    localparam int MAX_US    = 200;

    typedef struct packed {
        logic [1:0] lock_wait;
        logic       fs_ignore;
        logic       force_err;
        logic [1:0] sw_wait;
        logic       par_mode;
        logic       src_nonpcm;
    } aef_cfg_t;

    typedef enum logic [1:0] {
        SW_200US = 2'b00,
        SW_100US = 2'b01,
        SW_50US  = 2'b10,
        SW_NOW   = 2'b11
    } sw_code_e;

    function automatic logic [PRE_CNT_W-1:0] preamble_target(input logic [1:0] code);
        case (code)
            2'b00:   return PRE_CNT_W'(3);
            2'b01:   return PRE_CNT_W'(24);
            2'b10:   return PRE_CNT_W'(12);
            default: return PRE_CNT_W'(6);
        endcase
    endfunction

    function automatic int switch_delay_us(input int code);
        case (code)
            0:       return 200;
            1:       return 100;
            2:       return 50;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/aef_cfg_reg.sv
module aef_cfg_reg
    import aef_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output aef_cfg_t         cfg_o
);

    aef_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= aef_cfg_t'(wdata);
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/aef_error_events.sv
module aef_error_events (
    input  logic pll_locked,
    input  logic data_err_p,
    input  logic fs_chg_calc_p,
    input  logic fs_chg_cs_p,
    input  logic osc_running,
    input  logic fs_ignore,
    output logic fs_event,
    output logic restart
);

    logic calc_valid;

    // rate-calculator result is meaningless while the oscillator is stopped
    assign calc_valid = fs_chg_calc_p & osc_running;
    assign fs_event   = ~fs_ignore & (calc_valid | fs_chg_cs_p);
    assign restart    = ~pll_locked | data_err_p | fs_event;

endmodule

// File: rtl/aef_lock_qual.sv
module aef_lock_qual
    import aef_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       blk_start_p,
    input  logic [1:0] wait_code,
    output logic       released
);

    logic [PRE_CNT_W-1:0] cnt_q;
    logic [PRE_CNT_W-1:0] cnt_inc;
    logic [PRE_CNT_W-1:0] target;
    logic                 rel_q;

    assign target  = preamble_target(wait_code);
    assign cnt_inc = cnt_q + PRE_CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else if (!rel_q && blk_start_p) begin
            cnt_q <= cnt_inc;
            if (cnt_inc >= target) begin
                rel_q <= 1'b1;
            end
        end
    end

    assign released = rel_q;

endmodule

// File: rtl/aef_switch_timer.sv
module aef_switch_timer
    import aef_pkg::*;
#(
    parameter int CLK_KHZ = 250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pll_locked,
    input  logic [1:0] sw_code,
    output logic       switch_req
);

    localparam int MAX_CYC = (CLK_KHZ * MAX_US) / 1000;
    localparam int CNT_W   = $clog2(MAX_CYC + 2);

    logic [CNT_W-1:0] limit [3];
    logic [CNT_W-1:0] tmr_q;
    logic [CNT_W-1:0] tmr_inc;
    logic [CNT_W-1:0] lim_sel;
    logic             done_q;

    for (genvar g = 0; g < 3; g++) begin : g_lim
        localparam int CYC = (CLK_KHZ * switch_delay_us(g)) / 1000;
        assign limit[g] = CNT_W'(CYC < 1 ? 1 : CYC);
    end

    assign lim_sel = (sw_code == SW_NOW) ? CNT_W'(1) : limit[sw_code];
    assign tmr_inc = tmr_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || pll_locked) begin
            tmr_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            tmr_q <= tmr_inc;
            if (tmr_inc >= lim_sel) begin
                done_q <= 1'b1;
            end
        end
    end

    assign switch_req = ~pll_locked & ((sw_code == SW_NOW) | done_q);

endmodule

// File: rtl/aef_flag_mux.sv
module aef_flag_mux
    import aef_pkg::*;
(
    input  aef_cfg_t cfg,
    input  logic     released,
    input  logic     nonpcm_det,
    input  logic     parity_err_p,
    output logic     err_flag,
    output logic     audio_mute,
    output logic     parity_flag
);

    logic nonpcm_err;
    logic core_err;

    assign nonpcm_err  = cfg.src_nonpcm & nonpcm_det;
    assign core_err    = ~released | nonpcm_err;
    assign err_flag    = cfg.force_err | core_err;
    assign audio_mute  = core_err;
    assign parity_flag = cfg.par_mode ? parity_err_p : (parity_err_p & nonpcm_det);

endmodule

// File: rtl/audio_errflag_ctrl.sv
module audio_errflag_ctrl
    import aef_pkg::*;
#(
    parameter int CLK_KHZ = 250000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             pll_locked,
    input  logic             data_err_p,
    input  logic             parity_err_p,
    input  logic             nonpcm_det,
    input  logic             blk_start_p,
    input  logic             fs_chg_calc_p,
    input  logic             fs_chg_cs_p,
    input  logic             osc_running,
    output logic             err_flag,
    output logic             audio_mute,
    output logic             clk_switch_req,
    output logic             parity_flag
);

    aef_cfg_t   cfg;
    logic       fs_event;
    logic       restart;
    logic       released;
    logic       force_en;
    logic       src_sel;
    logic [1:0] sw_code;

    assign force_en = cfg.force_err;
    assign src_sel  = cfg.src_nonpcm;
    assign sw_code  = cfg.sw_wait;

    aef_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    aef_error_events u_evt (
        .pll_locked    (pll_locked),
        .data_err_p    (data_err_p),
        .fs_chg_calc_p (fs_chg_calc_p),
        .fs_chg_cs_p   (fs_chg_cs_p),
        .osc_running   (osc_running),
        .fs_ignore     (cfg.fs_ignore),
        .fs_event      (fs_event),
        .restart       (restart)
    );

    aef_lock_qual u_qual (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .blk_start_p (blk_start_p),
        .wait_code   (cfg.lock_wait),
        .released    (released)
    );

    aef_switch_timer #(.CLK_KHZ(CLK_KHZ)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .pll_locked (pll_locked),
        .sw_code    (sw_code),
        .switch_req (clk_switch_req)
    );

    aef_flag_mux u_mux (
        .cfg          (cfg),
        .released     (released),
        .nonpcm_det   (nonpcm_det),
        .parity_err_p (parity_err_p),
        .err_flag     (err_flag),
        .audio_mute   (audio_mute),
        .parity_flag  (parity_flag)
    );

endmodule

// File: rtl/aef_checker.sv
module aef_checker (
    input logic       clk,
    input logic       rst,
    input logic       pll_locked,
    input logic       nonpcm_det,
    input logic       blk_start_p,
    input logic       err_flag,
    input logic       audio_mute,
    input logic       clk_switch_req,
    input logic       force_en,
    input logic       src_sel,
    input logic [1:0] sw_code,
    input logic       released
);

    // R6
    force_flag_chk: assert property (@(posedge clk) disable iff (rst)
        force_en |-> err_flag);

    // R3
    unlock_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !pll_locked |=> err_flag);

    // R9
    locked_noswitch_chk: assert property (@(posedge clk) disable iff (rst)
        pll_locked |-> !clk_switch_req);

    // R10
    immediate_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (!pll_locked && sw_code == 2'b11) |-> clk_switch_req);

    // R5
    nonpcm_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (src_sel && nonpcm_det) |-> audio_mute);

    // R2
    release_on_preamble_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(released) |-> $past(blk_start_p));

endmodule

bind audio_errflag_ctrl aef_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .pll_locked     (pll_locked),
    .nonpcm_det     (nonpcm_det),
    .blk_start_p    (blk_start_p),
    .err_flag       (err_flag),
    .audio_mute     (audio_mute),
    .clk_switch_req (clk_switch_req),
    .force_en       (force_en),
    .src_sel        (src_sel),
    .sw_code        (sw_code),
    .released       (released)
);

// File: tb/audio_errflag_ctrl_tb_top.sv
module audio_errflag_ctrl_tb_top;

    localparam int CLK_KHZ = 10000;
    localparam int NVEC    = 4;
    // {cfg byte, release count}
    localparam logic [12:0] VEC [NVEC] = '{
        {8'h00, 5'd3}, {8'h40, 5'd24}, {8'h80, 5'd12}, {8'hC0, 5'd6}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       pll_locked = 1'b1;
    logic       data_err_p = 1'b0;
    logic       parity_err_p = 1'b0;
    logic       nonpcm_det = 1'b0;
    logic       blk_start_p = 1'b0;
    logic       fs_chg_calc_p = 1'b0;
    logic       fs_chg_cs_p = 1'b0;
    logic       osc_running = 1'b1;
    logic       err_flag, audio_mute, clk_switch_req, parity_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    audio_errflag_ctrl #(.CLK_KHZ(CLK_KHZ)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .pll_locked(pll_locked), .data_err_p(data_err_p),
        .parity_err_p(parity_err_p), .nonpcm_det(nonpcm_det),
        .blk_start_p(blk_start_p), .fs_chg_calc_p(fs_chg_calc_p),
        .fs_chg_cs_p(fs_chg_cs_p), .osc_running(osc_running),
        .err_flag(err_flag), .audio_mute(audio_mute),
        .clk_switch_req(clk_switch_req), .parity_flag(parity_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] b);
        cfg_we = 1'b1; cfg_wdata = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic preambles(input int n);
        for (int i = 0; i < n; i++) begin
            blk_start_p = 1'b1;
            @(negedge clk);
            blk_start_p = 1'b0;
        end
    endtask

    task automatic pulse_unlock();
        pll_locked = 1'b0;
        @(negedge clk);
        pll_locked = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 err_flag", err_flag, 1'b1);
        check("R1 audio_mute", audio_mute, 1'b1);
        check("R1 parity_flag", parity_flag, 1'b0);
        // R12 default code 00 releases after 3; nonpcm ignored with src bit 0
        preambles(3);
        check("R12 default release", err_flag, 1'b0);
        nonpcm_det = 1'b1; #1;
        check("R4 nonpcm ignored", err_flag, 1'b0);
        nonpcm_det = 1'b0;
        cfg_wdata = 8'h10; @(negedge clk);
        check("R12 no write without strobe", err_flag, 1'b0);

        // R2 table walk over release counts
        for (int v = 0; v < NVEC; v++) begin
            write_cfg(VEC[v][12:5]);
            pulse_unlock();
            preambles(int'(VEC[v][4:0]) - 1);
            check("R2 held before last", err_flag, 1'b1);
            preambles(1);
            check("R2 released at count", err_flag, 1'b0);
            check("R5 mute released", audio_mute, 1'b0);
        end

        // R3 data error restarts, full count needed again
        write_cfg(8'h00);
        data_err_p = 1'b1; @(negedge clk); data_err_p = 1'b0;
        check("R3 data error", err_flag, 1'b1);
        preambles(2);
        check("R3 partial count", err_flag, 1'b1);
        preambles(1);
        check("R3 full count", err_flag, 1'b0);
        pulse_unlock();
        check("R3 unlock", err_flag, 1'b1);
        preambles(3);

        // R7 fs change counted / gated
        fs_chg_calc_p = 1'b1; @(negedge clk); fs_chg_calc_p = 1'b0;
        check("R7 calc fs change", err_flag, 1'b1);
        preambles(3);
        // R8 oscillator stopped
        osc_running = 1'b0;
        fs_chg_calc_p = 1'b1; @(negedge clk); fs_chg_calc_p = 1'b0;
        check("R8 calc ignored", err_flag, 1'b0);
        fs_chg_cs_p = 1'b1; @(negedge clk); fs_chg_cs_p = 1'b0;
        check("R8 cs counted", err_flag, 1'b1);
        osc_running = 1'b1;
        preambles(3);
        write_cfg(8'h20);
        fs_chg_cs_p = 1'b1; fs_chg_calc_p = 1'b1; @(negedge clk);
        fs_chg_cs_p = 1'b0; fs_chg_calc_p = 1'b0;
        check("R7 gated", err_flag, 1'b0);

        // R4 R5 R6 nonpcm source, forced error together
        write_cfg(8'h11);
        nonpcm_det = 1'b1; #1;
        check("R6 force with nonpcm flag", err_flag, 1'b1);
        check("R5 nonpcm mute", audio_mute, 1'b1);
        nonpcm_det = 1'b0; #1;
        check("R6 force flag", err_flag, 1'b1);
        check("R6 force no mute", audio_mute, 1'b0);
        @(negedge clk);
        write_cfg(8'h01);
        check("R4 flag clear", err_flag, 1'b0);
        nonpcm_det = 1'b1; #1;
        check("R4 nonpcm flag", err_flag, 1'b1);
        nonpcm_det = 1'b0;
        @(negedge clk);

        // R11 parity modes
        write_cfg(8'h00);
        parity_err_p = 1'b1; #1;
        check("R11 mode0 no nonpcm", parity_flag, 1'b0);
        nonpcm_det = 1'b1; #1;
        check("R11 mode0 nonpcm", parity_flag, 1'b1);
        parity_err_p = 1'b0; nonpcm_det = 1'b0;
        @(negedge clk);
        write_cfg(8'h02);
        parity_err_p = 1'b1; #1;
        check("R11 mode1 pulse", parity_flag, 1'b1);
        parity_err_p = 1'b0; #1;
        check("R11 mode1 idle", parity_flag, 1'b0);
        @(negedge clk);

        // R9 R10 clock switch delays, unlock during count in progress
        for (int code = 0; code < 3; code++) begin
            int cyc;
            cyc = (CLK_KHZ * ((code == 0) ? 200 : (code == 1) ? 100 : 50)) / 1000;
            write_cfg(8'(code << 2));
            preambles(1);
            pll_locked = 1'b0;
            repeat (cyc - 1) @(negedge clk);
            check("R9 before delay", clk_switch_req, 1'b0);
            check("R3 flag after unlock", err_flag, 1'b1);
            @(negedge clk);
            check("R9 at delay", clk_switch_req, 1'b1);
            pll_locked = 1'b1; #1;
            check("R9 relock clears", clk_switch_req, 1'b0);
            @(negedge clk);
        end
        write_cfg(8'h0C);
        pll_locked = 1'b0; #1;
        check("R10 immediate", clk_switch_req, 1'b1);
        @(negedge clk);
        pll_locked = 1'b1; #1;
        check("R10 relock", clk_switch_req, 1'b0);
        @(negedge clk);

        finish_run();
    end

endmodule